// File: doc/BRIEF.md
# Instruction Byte Window

This block sits between a byte-wide program memory and an instruction decoder for a variable-length instruction format. Instructions are one, two or three bytes long. The block fetches bytes in order from the current instruction address into a small circular queue. Once three bytes are buffered, it tells the decoder that a window is ready. The window shows the first byte as the opcode. It shows the second byte twice, once zero-extended and once sign-extended to 16 bits, and it shows the second and third bytes together as a 16-bit little-endian word.

After decoding, the consumer reports how many bytes the instruction occupied, and the window moves forward by that many. Fetching is decoupled from consumption. Requests go out through a request/ready handshake, and bytes come back in order on a separate valid strobe. On a jump or branch, a redirect with a new address clears everything buffered and marks every request still in flight as stale. Stale bytes are dropped when they return, and filling restarts at the new address.

Top module: `ibw_window`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `win_valid_o` is 0. Fetching then begins at address `RESET_ADDR`, which defaults to 0.
- R2: `win_valid_o` is 1 only when at least three consecutive bytes from the current instruction address have arrived. With only two bytes arrived it stays 0.
- R3: `opcode_o` equals the memory byte at the current instruction address.
- R4: `imm_zx_o` equals the byte at address+1, zero-extended to 16 bits (bits 15:8 are 0).
- R5: `imm_sx_o` equals the byte at address+1, sign-extended from its bit 7 to 16 bits.
- R6: `word_o` is little-endian. Bits 7:0 hold the byte at address+1 and bits 15:8 hold the byte at address+2, with addresses wrapping modulo 2^AW.
- R7: The `consume_i` code gives the advance: 0 means no advance, and 1, 2 or 3 advance the current address by that many bytes. A byte that arrives in the same cycle is still kept. A code larger than the number of buffered bytes is illegal.
- R8: A redirect drops all buffered bytes. `win_valid_o` is 0 in the next cycle. Bytes from requests issued before or during the redirect cycle are discarded when they return, and the window is rebuilt from the new address.
- R9: Requests carry consecutive addresses, wrapping modulo 2^AW. A request waiting for ready keeps its address stable. After a redirect, the first request carries the redirect address.
- R10: Buffered bytes plus live requests never exceed DEPTH. With no responses returning, exactly DEPTH requests are accepted after a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_i | input | 1 | Flush the window and restart fetching at redirect_addr_i |
| redirect_addr_i | input | AW | New instruction address |
| consume_i | input | 2 | Bytes used by the current instruction (0 to 3) |
| win_valid_o | output | 1 | Three bytes are present at the current address |
| opcode_o | output | 8 | Byte at the current address |
| imm_zx_o | output | 16 | Second byte, zero-extended |
| imm_sx_o | output | 16 | Second byte, sign-extended |
| word_o | output | 16 | Second and third bytes, little-endian |
| mem_req_o | output | 1 | Fetch request |
| mem_addr_o | output | AW | Fetch address |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | A returned byte is present (responses in request order) |
| mem_rdata_i | input | 8 | Returned byte |

## Verification
The bench builds the block with AW = 8, DEPTH = 4 and MAX_OUT = 8. The 8-bit address space lets both the fetch address and the decoder position wrap past 0xFF many times. It also puts a directed window straddling 0xFE..0x00 within reach, so the little-endian word is formed across the wrap. A queue of four bytes fills up often under random ready and response rates, which exercises the credit limit, same-cycle arrival and advance, and redirects that land while up to eight requests are outstanding. That last case forces returning stale bytes to be discarded.

// File: rtl/ibw_pkg.sv
package ibw_pkg;

    // Bytes that must be present before a window is offered.
    localparam int unsigned WIN_BYTES = 3;

    // Advance code reported by the consumer.
    typedef enum logic [1:0] {
        ADV_NONE  = 2'd0,
        ADV_ONE   = 2'd1,
        ADV_TWO   = 2'd2,
        ADV_THREE = 2'd3
    } ibw_adv_e;

    // A byte arriving from memory and headed for the queue.
    typedef struct packed {
        logic       en;
        logic [7:0] data;
    } ibw_push_t;

    // The decoded view of the three window bytes.
    typedef struct packed {
        logic [7:0]  opcode;
        logic [15:0] imm_zx;
        logic [15:0] imm_sx;
        logic [15:0] word;
    } ibw_fields_t;

    function automatic ibw_fields_t form_fields(input logic [7:0] b0,
                                                input logic [7:0] b1,
                                                input logic [7:0] b2);
        ibw_fields_t f;
        f.opcode = b0;
        f.imm_zx = {8'h00, b1};
        f.imm_sx = {{8{b1[7]}}, b1};
        f.word   = {b2, b1};
        return f;
    endfunction

endpackage

// File: rtl/ibw_byte_queue.sv
module ibw_byte_queue
    import ibw_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            flush,
    input  ibw_push_t                       push,
    input  ibw_adv_e                        pop_cnt,
    output logic [WIN_BYTES-1:0][7:0]       win_o,
    output logic [CW-1:0]                   fill_o
);

    logic [7:0]    store_q [DEPTH];
    logic [PW-1:0] rd_q;
    logic [PW-1:0] wr_q;
    logic [CW-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_q   <= '0;
            wr_q   <= '0;
            fill_q <= '0;
        end else begin
            if (push.en) begin
                wr_q <= wr_q + 1'b1;
            end
            rd_q   <= rd_q + PW'(pop_cnt);
            fill_q <= fill_q + CW'(push.en) - CW'(pop_cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (push.en && !flush) begin
            store_q[wr_q] <= push.data;
        end
    end

    for (genvar k = 0; k < WIN_BYTES; k++) begin : g_win
        logic [PW-1:0] idx;
        assign idx      = rd_q + PW'(k);
        assign win_o[k] = store_q[idx];
    end

    assign fill_o = fill_q;

endmodule

// File: rtl/ibw_fetch.sv
module ibw_fetch
    import ibw_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DEPTH      = 4,
    parameter int MAX_OUT    = 8,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int OW = $clog2(MAX_OUT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redirect,
    input  logic [AW-1:0] redirect_addr,
    input  logic [CW-1:0] fill_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ready_i,
    input  logic          mem_rvalid_i,
    input  logic [7:0]    mem_rdata_i,
    output ibw_push_t     push_o,
    output logic [OW-1:0] live_o
);

    logic [AW-1:0] addr_q;
    logic [OW-1:0] live_q;
    logic [OW-1:0] stale_q;
    logic          accept;
    logic          keep;
    logic          drop;

    // Issue only while the queue has room for every live request and the
    // outstanding total stays within what the counters can track.
    assign mem_req_o = ((32'(fill_i) + 32'(live_q)) < 32'(DEPTH)) &&
                       ((32'(stale_q) + 32'(live_q)) < 32'(MAX_OUT));
    assign mem_addr_o = addr_q;
    assign accept     = mem_req_o && mem_ready_i;
    assign drop       = mem_rvalid_i && (stale_q != '0);
    assign keep       = mem_rvalid_i && (stale_q == '0) && !redirect;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= RESET_ADDR;
            live_q  <= '0;
            stale_q <= '0;
        end else if (redirect) begin
            addr_q  <= redirect_addr;
            live_q  <= '0;
            stale_q <= stale_q + live_q + OW'(accept) - OW'(mem_rvalid_i);
        end else begin
            if (accept) begin
                addr_q <= addr_q + 1'b1;
            end
            live_q  <= live_q + OW'(accept) - OW'(keep);
            stale_q <= stale_q - OW'(drop);
        end
    end

    assign push_o.en   = keep;
    assign push_o.data = mem_rdata_i;
    assign live_o      = live_q;

endmodule

// File: rtl/ibw_fields_fmt.sv
module ibw_fields_fmt
    import ibw_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [WIN_BYTES-1:0][7:0] win_i,
    input  logic [CW-1:0]             fill_i,
    output ibw_fields_t               fields_o,
    output logic                      valid_o
);

    assign valid_o  = fill_i >= CW'(WIN_BYTES);
    assign fields_o = form_fields(win_i[0], win_i[1], win_i[2]);

endmodule

// File: rtl/ibw_window.sv
module ibw_window
    import ibw_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DEPTH      = 4,
    parameter int MAX_OUT    = 8,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          redirect_i,
    input  logic [AW-1:0] redirect_addr_i,
    input  logic [1:0]    consume_i,
    output logic          win_valid_o,
    output logic [7:0]    opcode_o,
    output logic [15:0]   imm_zx_o,
    output logic [15:0]   imm_sx_o,
    output logic [15:0]   word_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ready_i,
    input  logic          mem_rvalid_i,
    input  logic [7:0]    mem_rdata_i
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int OW = $clog2(MAX_OUT + 1);

    ibw_push_t                 arr_push;
    ibw_adv_e                  adv;
    ibw_fields_t               fields;
    logic [WIN_BYTES-1:0][7:0] win_bytes;
    logic [CW-1:0]             q_fill;
    logic [OW-1:0]             f_live;

    assign adv = ibw_adv_e'(consume_i);

    ibw_fetch #(
        .AW(AW), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .redirect     (redirect_i),
        .redirect_addr(redirect_addr_i),
        .fill_i       (q_fill),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_ready_i  (mem_ready_i),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .push_o       (arr_push),
        .live_o       (f_live)
    );

    ibw_byte_queue #(.DEPTH(DEPTH)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .flush  (redirect_i),
        .push   (arr_push),
        .pop_cnt(adv),
        .win_o  (win_bytes),
        .fill_o (q_fill)
    );

    ibw_fields_fmt #(.DEPTH(DEPTH)) u_fmt (
        .win_i   (win_bytes),
        .fill_i  (q_fill),
        .fields_o(fields),
        .valid_o (win_valid_o)
    );

    assign opcode_o = fields.opcode;
    assign imm_zx_o = fields.imm_zx;
    assign imm_sx_o = fields.imm_sx;
    assign word_o   = fields.word;

endmodule

// File: rtl/ibw_window_chk.sv
module ibw_window_chk #(
    parameter int AW      = 16,
    parameter int DEPTH   = 4,
    parameter int MAX_OUT = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int OW = $clog2(MAX_OUT + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          redirect_i,
    input logic [AW-1:0] redirect_addr_i,
    input logic [1:0]    consume_i,
    input logic          win_valid_o,
    input logic [7:0]    opcode_o,
    input logic [15:0]   imm_zx_o,
    input logic [15:0]   imm_sx_o,
    input logic [15:0]   word_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_ready_i,
    input logic [CW-1:0] fill,
    input logic [OW-1:0] live
);

    // R8
    redirect_blanks_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> !win_valid_o);

    // R9
    redirect_addr_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> mem_addr_o == $past(redirect_addr_i));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ready_i && !redirect_i |=> mem_req_o && $stable(mem_addr_o));

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_ready_i && !redirect_i |=> mem_addr_o == AW'($past(mem_addr_o) + 1'b1));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(fill) + 32'(live)) <= 32'(DEPTH));

    // R7
    legal_consume_chk: assert property (@(posedge clk) disable iff (rst)
        32'(consume_i) <= 32'(fill));

    // R7
    hold_window_chk: assert property (@(posedge clk) disable iff (rst)
        win_valid_o && consume_i == 2'd0 && !redirect_i |=> win_valid_o && $stable(opcode_o) && $stable(word_o));

    // R5
    sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
        imm_sx_o[7:0] == imm_zx_o[7:0] && imm_sx_o[15:8] == {8{imm_zx_o[7]}});

    // R6
    word_low_chk: assert property (@(posedge clk) disable iff (rst)
        word_o[7:0] == imm_zx_o[7:0]);

endmodule

bind ibw_window ibw_window_chk #(
    .AW(AW), .DEPTH(DEPTH), .MAX_OUT(MAX_OUT)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .redirect_i     (redirect_i),
    .redirect_addr_i(redirect_addr_i),
    .consume_i      (consume_i),
    .win_valid_o    (win_valid_o),
    .opcode_o       (opcode_o),
    .imm_zx_o       (imm_zx_o),
    .imm_sx_o       (imm_sx_o),
    .word_o         (word_o),
    .mem_req_o      (mem_req_o),
    .mem_addr_o     (mem_addr_o),
    .mem_ready_i    (mem_ready_i),
    .fill           (q_fill),
    .live           (f_live)
);

// File: tb/sim_ibw_window.sv
`timescale 1ns/1ps
module sim_ibw_window;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          redirect_i = 1'b0;
    logic [AW-1:0] redirect_addr_i = '0;
    logic [1:0]    consume_i = 2'd0;
    logic          win_valid_o;
    logic [7:0]    opcode_o;
    logic [15:0]   imm_zx_o;
    logic [15:0]   imm_sx_o;
    logic [15:0]   word_o;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_ready_i = 1'b0;
    logic          mem_rvalid_i = 1'b0;
    logic [7:0]    mem_rdata_i = 8'h00;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int rdy_pct   = 100;
    int rv_pct    = 100;
    int rv_budget = -1;
    int accepts   = 0;
    int valid_cycles = 0;
    logic [AW-1:0] pend_q[$];
    logic [AW-1:0] acc_log[$];
    logic [AW-1:0] pc;

    ibw_window #(.AW(AW), .DEPTH(4), .MAX_OUT(8)) u0 (.*);

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return (a * 8'd37) ^ 8'hC3 ^ {a[3:0], a[7:4]};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Compare the four window fields against memory at pc.
    task automatic check_fields(input string tag);
        logic [7:0] b0, b1, b2;
        b0 = mem_byte(pc);
        b1 = mem_byte(pc + 8'd1);
        b2 = mem_byte(pc + 8'd2);
        chk(opcode_o == b0, {"R3 opcode ", tag}, 32'(opcode_o), 32'(b0));
        chk(imm_zx_o == {8'h00, b1}, {"R4 zero-extended ", tag}, 32'(imm_zx_o), 32'({8'h00, b1}));
        chk(imm_sx_o == {{8{b1[7]}}, b1}, {"R5 sign-extended ", tag}, 32'(imm_sx_o), 32'({{8{b1[7]}}, b1}));
        chk(word_o == {b2, b1}, {"R6 word ", tag}, 32'(word_o), 32'({b2, b1}));
    endtask

    // One clock: drive memory side at the negedge, then advance.
    task automatic cycle();
        if (pend_q.size() > 0 && rv_budget != 0 && int'($urandom % 100) < rv_pct) begin
            mem_rvalid_i = 1'b1;
            mem_rdata_i  = mem_byte(pend_q.pop_front());
            if (rv_budget > 0) rv_budget--;
        end else begin
            mem_rvalid_i = 1'b0;
        end
        mem_ready_i = int'($urandom % 100) < rdy_pct;
        if (mem_req_o && mem_ready_i) begin
            pend_q.push_back(mem_addr_o);
            acc_log.push_back(mem_addr_o);
            accepts++;
        end
        @(posedge clk);
        @(negedge clk);
        redirect_i = 1'b0;
        consume_i  = 2'd0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int stale_cnt;
        bit prev_redir;
        void'($urandom(32'd2024));

        // Reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(win_valid_o == 1'b0, "R1 valid during reset", 32'(win_valid_o), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(win_valid_o == 1'b0, "R1 valid after reset", 32'(win_valid_o), 0);
        chk(mem_req_o == 1'b1, "R1 request after reset", 32'(mem_req_o), 1);
        chk(mem_addr_o == 8'h00, "R1 start address", 32'(mem_addr_o), 0);

        // Let a few old requests go out, then redirect near the wrap point.
        rv_pct = 0;
        cycle(); cycle();
        redirect_i = 1'b1;
        redirect_addr_i = 8'hFE;
        cycle();
        chk(win_valid_o == 1'b0, "R8 valid after redirect", 32'(win_valid_o), 0);
        chk(mem_addr_o == 8'hFE, "R9 address after redirect", 32'(mem_addr_o), 32'hFE);
        stale_cnt = pend_q.size();
        acc_log.delete();
        accepts = 0;
        repeat (8) cycle();
        chk(accepts == 4, "R10 accepts with no responses", 32'(accepts), 4);
        if (acc_log.size() >= 4) begin
            chk(acc_log[0] == 8'hFE, "R9 seq 0", 32'(acc_log[0]), 32'hFE);
            chk(acc_log[1] == 8'hFF, "R9 seq 1", 32'(acc_log[1]), 32'hFF);
            chk(acc_log[2] == 8'h00, "R9 seq wrap", 32'(acc_log[2]), 32'h00);
            chk(acc_log[3] == 8'h01, "R9 seq 3", 32'(acc_log[3]), 32'h01);
        end

        // Stale bytes plus two fresh ones: still no window.
        rv_pct = 100;
        rv_budget = stale_cnt + 2;
        repeat (10) cycle();
        chk(win_valid_o == 1'b0, "R2 two bytes only", 32'(win_valid_o), 0);
        rv_budget = 1;
        repeat (3) cycle();
        chk(win_valid_o == 1'b1, "R2 third byte arrives", 32'(win_valid_o), 1);
        pc = 8'hFE;
        check_fields("wrap window");
        rv_budget = 1;
        repeat (3) cycle();

        // No advance, then one, then three (emptying the queue).
        chk(win_valid_o == 1'b1, "R7 hold with code 0", 32'(win_valid_o), 1);
        check_fields("hold");
        consume_i = 2'd1;
        pc = pc + 8'd1;
        cycle();
        chk(win_valid_o == 1'b1, "R7 after advance by one", 32'(win_valid_o), 1);
        check_fields("advance one");
        consume_i = 2'd3;
        pc = pc + 8'd3;
        cycle();
        chk(win_valid_o == 1'b0, "R7 after advance by three", 32'(win_valid_o), 0);

        // Random phase: variable readiness, advances and redirects.
        rv_budget = -1;
        prev_redir = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            rdy_pct = (i % 1000 < 500) ? 70 : 30;
            rv_pct  = (i % 700 < 350) ? 80 : 40;
            if (prev_redir) begin
                chk(win_valid_o == 1'b0, "R8 blank after redirect", 32'(win_valid_o), 0);
            end
            prev_redir = 1'b0;
            if (win_valid_o) begin
                valid_cycles++;
                check_fields("random R7");
            end
            if ($urandom % 40 == 0) begin
                redirect_i = 1'b1;
                redirect_addr_i = ($urandom % 4 == 0) ? 8'hFD : 8'($urandom);
                pc = redirect_addr_i;
                prev_redir = 1'b1;
            end else if (win_valid_o) begin
                consume_i = 2'($urandom % 4);
                pc = pc + 8'(consume_i);
            end
            cycle();
        end
        chk(valid_cycles > 500, "R7 steady progress", 32'(valid_cycles), 500);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule